// File: doc/BRIEF.md
# SCSI Bus-Master DMA Channel Register File

This block is the register file and counter logic of a single bus-master DMA channel that sits next to a SCSI protocol core. A host reaches it through one 32-bit read/write port addressed by a three-bit word index. A two-bit operation field in the command word idles, aborts or starts the channel. Start copies the programmed starting count, address and descriptor address into working copies. After that the working address counts up and the working byte count counts down as data moves.

The data mover outside this block presents each transfer through a move handshake, giving the requested length and direction. The block answers in the same cycle with the granted chunk, which is the request clipped to the remaining count, or with a refusal when the direction does not match the programmed direction. A level input from a separate bus-control register picks the status-clear policy: write-one-to-clear, or clear on read. The SCSI core's interrupt line and its command-complete pulse feed the status word and the interrupt output.

Top module: `scsi_dma_regs`

## Requirements
- R1: After reset the command word, start count, start address, start descriptor address, working count and stored done flag read 0. The working address reads 0xFFFFFFFF, the working descriptor address reads 0xFFFFFFFD, and dma_en and irq are 0.
- R2: Word index map: 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor address, 7 working descriptor address. Writes to 1, 2 and 6 store the full word. Writes to 3, 4 and 7 are ignored. The command word keeps only bits [7:0], and bits [31:8] read 0.
- R3: Command bits [1:0] give the operation. Value 0 clears dma_en. Value 1 changes nothing apart from storing the command byte. Value 2 drives abort_req high during the writing cycle. Value 3 starts the channel.
- R4: A start loads the working count from the start count, the working address from the start address and the working descriptor address from the start descriptor address. It also clears done (status bit 3) and sets dma_en.
- R5: An accepted move grants mv_chunk = min(mv_len, working count). It lowers the working count and raises the working address by that chunk. Done is set when the resulting count is zero.
- R6: A move whose mv_dir (1 = device to memory) differs from command bit 7 raises mv_refuse and leaves both working counters unchanged.
- R7: With w1c_mode high, a status write clears done when written bit 3 is 1. A write with bit 3 at 0 leaves done set.
- R8: With w1c_mode low, status writes are ignored, and a status read returns done and then clears it.
- R9: Status bit 4 follows core_irq live on every read and is not stored.
- R10: A cmd_complete pulse forces the working count to 0 and sets done.
- R11: irq is high when done is set and command bit 6 (done interrupt enable) is 1, or when core_irq is high.
- R12: A done set in the same cycle as a status clear leaves done set. A start write in the same cycle as cmd_complete or a move wins: the working count takes the start count and done ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (drives clear-on-read) |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for reg_idx (combinational) |
| w1c_mode | input | 1 | 1: status write-one-to-clear, 0: clear on read |
| mv_valid | input | 1 | Move request valid this cycle |
| mv_dir | input | 1 | Move direction, 1 = device to memory |
| mv_len | input | 16 | Requested move length in bytes |
| mv_chunk | output | 16 | Granted chunk length |
| mv_refuse | output | 1 | Move refused (direction mismatch) |
| core_irq | input | 1 | SCSI core interrupt line |
| cmd_complete | input | 1 | SCSI command complete pulse |
| dma_en | output | 1 | Channel enabled |
| abort_req | output | 1 | Abort request to the core |
| irq | output | 1 | Channel interrupt |

## Verification
The bound checker watches, on every cycle, the relations between the handshake and the working counters: start loading and enabling, idle disabling, the per-move count and address step, a granted chunk never exceeding the remaining count, refused moves holding the counters, completion zeroing the count, and the interrupt following done and its enable. The status-clear policies depend on the mode input and on host read strobes, so the bench's scenarios are what show them: writes that are ignored in clear-on-read mode, a read that returns done once, and write-one-to-clear with a zero and a one in bit 3. The bench also checks the register map, reset values and the same-cycle priority cases directly at the ports.

// File: rtl/sdma_pkg.sv
`timescale 1ns/1ps
package sdma_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_BLAST = 2'd1,
        OP_ABORT = 2'd2,
        OP_START = 2'd3
    } op_e;

    localparam logic [2:0] IX_CMD  = 3'd0;
    localparam logic [2:0] IX_SCNT = 3'd1;
    localparam logic [2:0] IX_SADR = 3'd2;
    localparam logic [2:0] IX_WCNT = 3'd3;
    localparam logic [2:0] IX_WADR = 3'd4;
    localparam logic [2:0] IX_STAT = 3'd5;
    localparam logic [2:0] IX_SDSC = 3'd6;
    localparam logic [2:0] IX_WDSC = 3'd7;

    localparam int CMD_BITS   = 8;
    localparam int CMD_DONEIE = 6;
    localparam int CMD_DIR    = 7;
    localparam int ST_DONE    = 3;
    localparam int ST_CORE    = 4;
endpackage

// File: rtl/sdma_cmd_dec.sv
`timescale 1ns/1ps
module sdma_cmd_dec
    import sdma_pkg::*;
(
    input  logic       wr_en,
    input  logic [2:0] idx,
    input  logic [1:0] op,
    output logic       cmd_we,
    output logic       scnt_we,
    output logic       sadr_we,
    output logic       sdsc_we,
    output logic       stat_we,
    output logic       go_idle,
    output logic       go_abort,
    output logic       go_start
);
    always_comb begin
        cmd_we  = wr_en && (idx == IX_CMD);
        scnt_we = wr_en && (idx == IX_SCNT);
        sadr_we = wr_en && (idx == IX_SADR);
        sdsc_we = wr_en && (idx == IX_SDSC);
        stat_we = wr_en && (idx == IX_STAT);
        go_idle  = cmd_we && (op_e'(op) == OP_IDLE);
        go_abort = cmd_we && (op_e'(op) == OP_ABORT);
        go_start = cmd_we && (op_e'(op) == OP_START);
    end
endmodule

// File: rtl/sdma_chunk.sv
`timescale 1ns/1ps
module sdma_chunk #(
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          valid,
    input  logic          req_dir,
    input  logic          cfg_dir,
    input  logic [LW-1:0] req_len,
    input  logic [DW-1:0] remain,
    output logic [LW-1:0] chunk,
    output logic          refuse,
    output logic          take
);
    logic clip;
    always_comb begin
        clip   = remain < DW'(req_len);
        chunk  = clip ? remain[LW-1:0] : req_len;
        refuse = valid && (req_dir != cfg_dir);
        take   = valid && (req_dir == cfg_dir);
    end
endmodule

// File: rtl/sdma_rmux.sv
`timescale 1ns/1ps
module sdma_rmux
    import sdma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [2:0]          idx,
    input  logic [CMD_BITS-1:0] cmd,
    input  logic [DW-1:0]       scnt,
    input  logic [DW-1:0]       sadr,
    input  logic [DW-1:0]       sdsc,
    input  logic [DW-1:0]       wcnt,
    input  logic [DW-1:0]       wadr,
    input  logic [DW-1:0]       wdsc,
    input  logic                done,
    input  logic                core_irq,
    output logic [DW-1:0]       rdata
);
    always_comb begin
        unique case (idx)
            IX_CMD:  rdata = DW'(cmd);
            IX_SCNT: rdata = scnt;
            IX_SADR: rdata = sadr;
            IX_WCNT: rdata = wcnt;
            IX_WADR: rdata = wadr;
            IX_STAT: rdata = DW'({core_irq, done, 3'b000});
            IX_SDSC: rdata = sdsc;
            default: rdata = wdsc;
        endcase
    end
endmodule

// File: rtl/scsi_dma_regs.sv
`timescale 1ns/1ps
module scsi_dma_regs
    import sdma_pkg::*;
#(
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_idx,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          w1c_mode,
    input  logic          mv_valid,
    input  logic          mv_dir,
    input  logic [LW-1:0] mv_len,
    output logic [LW-1:0] mv_chunk,
    output logic          mv_refuse,
    input  logic          core_irq,
    input  logic          cmd_complete,
    output logic          dma_en,
    output logic          abort_req,
    output logic          irq
);
    localparam logic [DW-1:0] WADR_RST = {DW{1'b1}};
    localparam logic [DW-1:0] WDSC_RST = {{(DW-2){1'b1}}, 2'b01};

    typedef struct packed {
        logic [CMD_BITS-1:0] cmd;
        logic [DW-1:0]       scnt;
        logic [DW-1:0]       sadr;
        logic [DW-1:0]       sdsc;
        logic [DW-1:0]       wcnt;
        logic [DW-1:0]       wadr;
        logic [DW-1:0]       wdsc;
        logic                done;
        logic                en;
    } regs_t;

    regs_t st_d, st_q;

    logic cmd_we, scnt_we, sadr_we, sdsc_we, stat_we;
    logic go_idle, go_abort, go_start;
    logic take;
    logic [DW-1:0] left;
    logic done_set, done_clr;

    sdma_cmd_dec u_dec (
        .wr_en    (reg_wr),
        .idx      (reg_idx),
        .op       (reg_wdata[1:0]),
        .cmd_we   (cmd_we),
        .scnt_we  (scnt_we),
        .sadr_we  (sadr_we),
        .sdsc_we  (sdsc_we),
        .stat_we  (stat_we),
        .go_idle  (go_idle),
        .go_abort (go_abort),
        .go_start (go_start)
    );

    sdma_chunk #(.DW(DW), .LW(LW)) u_chunk (
        .valid   (mv_valid),
        .req_dir (mv_dir),
        .cfg_dir (st_q.cmd[CMD_DIR]),
        .req_len (mv_len),
        .remain  (st_q.wcnt),
        .chunk   (mv_chunk),
        .refuse  (mv_refuse),
        .take    (take)
    );

    sdma_rmux #(.DW(DW)) u_rmux (
        .idx      (reg_idx),
        .cmd      (st_q.cmd),
        .scnt     (st_q.scnt),
        .sadr     (st_q.sadr),
        .sdsc     (st_q.sdsc),
        .wcnt     (st_q.wcnt),
        .wadr     (st_q.wadr),
        .wdsc     (st_q.wdsc),
        .done     (st_q.done),
        .core_irq (core_irq),
        .rdata    (reg_rdata)
    );

    always_comb begin
        st_d     = st_q;
        done_set = 1'b0;
        left     = st_q.wcnt - DW'(mv_chunk);
        done_clr = (stat_we && w1c_mode && reg_wdata[ST_DONE])
                || (reg_rd && (reg_idx == IX_STAT) && !w1c_mode);

        if (cmd_we)  st_d.cmd  = reg_wdata[CMD_BITS-1:0];
        if (scnt_we) st_d.scnt = reg_wdata;
        if (sadr_we) st_d.sadr = reg_wdata;
        if (sdsc_we) st_d.sdsc = reg_wdata;

        if (take) begin
            st_d.wcnt = left;
            st_d.wadr = st_q.wadr + DW'(mv_chunk);
            if (left == '0) done_set = 1'b1;
        end
        if (cmd_complete) begin
            st_d.wcnt = '0;
            done_set  = 1'b1;
        end

        st_d.done = (st_q.done && !done_clr) || done_set;

        if (go_idle) st_d.en = 1'b0;
        if (go_start) begin
            st_d.wcnt = st_q.scnt;
            st_d.wadr = st_q.sadr;
            st_d.wdsc = st_q.sdsc;
            st_d.done = 1'b0;
            st_d.en   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.wadr <= WADR_RST;
            st_q.wdsc <= WDSC_RST;
        end else begin
            st_q <= st_d;
        end
    end

    logic [DW-1:0] wcnt_q, wadr_q, scnt_q;
    logic          done_q, done_ie_q;

    always_comb begin
        dma_en    = st_q.en;
        abort_req = go_abort;
        irq       = (st_q.done && st_q.cmd[CMD_DONEIE]) || core_irq;
        wcnt_q    = st_q.wcnt;
        wadr_q    = st_q.wadr;
        scnt_q    = st_q.scnt;
        done_q    = st_q.done;
        done_ie_q = st_q.cmd[CMD_DONEIE];
    end
endmodule

// File: rtl/sdma_chk.sv
`timescale 1ns/1ps
module sdma_chk #(
    parameter int DW = 32,
    parameter int LW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [2:0]    reg_idx,
    input logic [DW-1:0] reg_wdata,
    input logic          mv_valid,
    input logic          mv_refuse,
    input logic [LW-1:0] mv_chunk,
    input logic          cmd_complete,
    input logic          irq,
    input logic          dma_en,
    input logic [DW-1:0] wcnt,
    input logic [DW-1:0] wadr,
    input logic [DW-1:0] scnt,
    input logic          done,
    input logic          done_ie
);
    logic start_w, idle_w, quiet;
    always_comb begin
        start_w = reg_wr && (reg_idx == 3'd0) && (reg_wdata[1:0] == 2'd3);
        idle_w  = reg_wr && (reg_idx == 3'd0) && (reg_wdata[1:0] == 2'd0);
        quiet   = !reg_wr && !cmd_complete;
    end

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> (wcnt == $past(scnt)) && dma_en && !done); // R4

    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        idle_w |=> !dma_en); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid && !mv_refuse && quiet) |=>
        (wcnt == $past(wcnt) - DW'($past(mv_chunk))) &&
        (wadr == $past(wadr) + DW'($past(mv_chunk)))); // R5

    AST_NO_OVERDRAW: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid |-> (DW'(mv_chunk) <= wcnt)); // R5

    AST_REFUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid && mv_refuse && quiet) |=> $stable(wcnt) && $stable(wadr)); // R6

    AST_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_complete && !start_w) |=> (wcnt == '0) && done); // R10

    AST_IRQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_ie) |-> irq); // R11
endmodule

bind scsi_dma_regs sdma_chk #(.DW(DW), .LW(LW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_idx      (reg_idx),
    .reg_wdata    (reg_wdata),
    .mv_valid     (mv_valid),
    .mv_refuse    (mv_refuse),
    .mv_chunk     (mv_chunk),
    .cmd_complete (cmd_complete),
    .irq          (irq),
    .dma_en       (dma_en),
    .wcnt         (wcnt_q),
    .wadr         (wadr_q),
    .scnt         (scnt_q),
    .done         (done_q),
    .done_ie      (done_ie_q)
);

// File: tb/sim_scsi_dma_regs.sv
`timescale 1ns/1ps
module sim_scsi_dma_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        w1c_mode = 1'b1;
    logic        mv_valid = 1'b0;
    logic        mv_dir = 1'b0;
    logic [15:0] mv_len = '0;
    logic [15:0] mv_chunk;
    logic        mv_refuse;
    logic        core_irq = 1'b0;
    logic        cmd_complete = 1'b0;
    logic        dma_en, abort_req, irq;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    scsi_dma_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .w1c_mode(w1c_mode), .mv_valid(mv_valid), .mv_dir(mv_dir),
        .mv_len(mv_len), .mv_chunk(mv_chunk), .mv_refuse(mv_refuse),
        .core_irq(core_irq), .cmd_complete(cmd_complete), .dma_en(dma_en),
        .abort_req(abort_req), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] i, input logic [31:0] v);
        @(negedge clk);
        reg_idx = i; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] i, output logic [31:0] v);
        @(negedge clk);
        reg_idx = i; reg_rd = 1'b1;
        #2 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic mv(input logic d, input logic [15:0] n,
                      output logic [15:0] ch, output logic rf);
        @(negedge clk);
        mv_dir = d; mv_len = n; mv_valid = 1'b1;
        #2 ch = mv_chunk; rf = mv_refuse;
        @(negedge clk);
        mv_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); chk("R1 cmd", v, 32'h0);
        rd(3'd1, v); chk("R1 scnt", v, 32'h0);
        rd(3'd3, v); chk("R1 wcnt", v, 32'h0);
        rd(3'd4, v); chk("R1 wadr", v, 32'hFFFF_FFFF);
        rd(3'd5, v); chk("R1 status", v, 32'h0);
        rd(3'd7, v); chk("R1 wdsc", v, 32'hFFFF_FFFD);
        chk("R1 dma_en", {31'b0, dma_en}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(3'd1, 32'h0000_0100);
        wr(3'd2, 32'h0000_1000);
        wr(3'd6, 32'h0000_2000);
        wr(3'd3, 32'h5);
        wr(3'd4, 32'h7);
        wr(3'd7, 32'h9);
        rd(3'd1, v); chk("R2 scnt", v, 32'h100);
        rd(3'd2, v); chk("R2 sadr", v, 32'h1000);
        rd(3'd6, v); chk("R2 sdsc", v, 32'h2000);
        rd(3'd3, v); chk("R2 wcnt write ignored", v, 32'h0);
        rd(3'd4, v); chk("R2 wadr write ignored", v, 32'hFFFF_FFFF);
        rd(3'd7, v); chk("R2 wdsc write ignored", v, 32'hFFFF_FFFD);
        wr(3'd0, 32'hFFFF_FF40);
        rd(3'd0, v); chk("R2 cmd upper bits", v, 32'h40);
    endtask

    task automatic t_start_move();
        logic [31:0] v; logic [15:0] ch; logic rf;
        wr(3'd0, 32'h03);
        rd(3'd3, v); chk("R4 wcnt load", v, 32'h100);
        rd(3'd4, v); chk("R4 wadr load", v, 32'h1000);
        rd(3'd7, v); chk("R4 wdsc load", v, 32'h2000);
        chk("R4 dma_en", {31'b0, dma_en}, 32'h1);
        mv(1'b0, 16'h40, ch, rf);
        chk("R5 chunk", {16'b0, ch}, 32'h40);
        rd(3'd3, v); chk("R5 wcnt step", v, 32'hC0);
        rd(3'd4, v); chk("R5 wadr step", v, 32'h1040);
        mv(1'b1, 16'h10, ch, rf);
        chk("R6 refuse", {31'b0, rf}, 32'h1);
        rd(3'd3, v); chk("R6 wcnt held", v, 32'hC0);
        rd(3'd4, v); chk("R6 wadr held", v, 32'h1040);
        mv(1'b0, 16'h200, ch, rf);
        chk("R5 clipped chunk", {16'b0, ch}, 32'hC0);
        rd(3'd3, v); chk("R5 wcnt zero", v, 32'h0);
        rd(3'd4, v); chk("R5 wadr end", v, 32'h1100);
        rd(3'd5, v); chk("R5 done set", v, 32'h08);
    endtask

    task automatic t_irq_blast();
        logic [31:0] v;
        wr(3'd0, 32'h41);
        chk("R11 irq done+enable", {31'b0, irq}, 32'h1);
        chk("R3 blast keeps dma_en", {31'b0, dma_en}, 32'h1);
        rd(3'd5, v); chk("R3 blast keeps done", v, 32'h08);
        wr(3'd0, 32'h01);
        chk("R11 irq off when disabled", {31'b0, irq}, 32'h0);
        @(negedge clk); core_irq = 1'b1;
        #2 chk("R11 irq from core", {31'b0, irq}, 32'h1);
        rd(3'd5, v); chk("R9 core bit in status", v, 32'h18);
        @(negedge clk); core_irq = 1'b0;
        rd(3'd5, v); chk("R9 core bit not stored", v, 32'h08);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        w1c_mode = 1'b1;
        wr(3'd5, 32'h0000_0017);
        rd(3'd5, v); chk("R7 zero bit3 keeps done", v, 32'h08);
        wr(3'd5, 32'h0000_0008);
        rd(3'd5, v); chk("R7 one clears done", v, 32'h0);
    endtask

    task automatic t_readclear();
        logic [31:0] v; logic [15:0] ch; logic rf;
        wr(3'd1, 32'h4);
        wr(3'd0, 32'h03);
        mv(1'b0, 16'h4, ch, rf);
        w1c_mode = 1'b0;
        wr(3'd5, 32'h08);
        rd(3'd5, v); chk("R8 write ignored, read shows done", v, 32'h08);
        rd(3'd5, v); chk("R8 read cleared done", v, 32'h0);
        w1c_mode = 1'b1;
    endtask

    task automatic t_dir_idle_abort();
        logic [31:0] v; logic [15:0] ch; logic rf;
        wr(3'd1, 32'h20);
        wr(3'd0, 32'h83);
        mv(1'b1, 16'h8, ch, rf);
        chk("R6 device-to-memory accepted", {31'b0, rf}, 32'h0);
        rd(3'd3, v); chk("R5 wcnt dir1", v, 32'h18);
        @(negedge clk);
        reg_idx = 3'd0; reg_wdata = 32'h82; reg_wr = 1'b1;
        #2 chk("R3 abort pulse", {31'b0, abort_req}, 32'h1);
        @(negedge clk); reg_wr = 1'b0;
        #2 chk("R3 abort pulse ends", {31'b0, abort_req}, 32'h0);
        wr(3'd0, 32'h80);
        chk("R3 idle clears dma_en", {31'b0, dma_en}, 32'h0);
    endtask

    task automatic t_complete();
        logic [31:0] v;
        wr(3'd1, 32'h50);
        wr(3'd0, 32'h03);
        @(negedge clk); cmd_complete = 1'b1;
        @(negedge clk); cmd_complete = 1'b0;
        rd(3'd3, v); chk("R10 wcnt forced 0", v, 32'h0);
        rd(3'd5, v); chk("R10 done set", v, 32'h08);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr(3'd1, 32'h8);
        wr(3'd0, 32'h03);
        @(negedge clk);
        mv_dir = 1'b0; mv_len = 16'h8; mv_valid = 1'b1;
        reg_idx = 3'd5; reg_wdata = 32'h08; reg_wr = 1'b1;
        @(negedge clk); mv_valid = 1'b0; reg_wr = 1'b0;
        rd(3'd5, v); chk("R12 set beats clear", v, 32'h08);
        @(negedge clk);
        cmd_complete = 1'b1;
        reg_idx = 3'd0; reg_wdata = 32'h03; reg_wr = 1'b1;
        @(negedge clk); cmd_complete = 1'b0; reg_wr = 1'b0;
        rd(3'd3, v); chk("R12 start beats complete wcnt", v, 32'h8);
        rd(3'd5, v); chk("R12 start beats complete done", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_start_move();
        t_irq_blast();
        t_w1c();
        t_readclear();
        t_dir_idle_abort();
        t_complete();
        t_priority();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule